// File: doc/BRIEF.md
# Shared-Terminal GPIO Control Register

A 32-bit control and status register that runs four general-purpose pins. Each pin has three control bits: a data bit, an output-enable bit and a polarity-invert bit. The invert bit acts on both directions. It flips the level driven onto the terminal, and it flips the sampled level that software reads back. Pin inputs reach the register through a synchronizer of two flops.

Two of the four terminals are shared with dedicated alternate functions. Out of reset these terminals carry their alternate function. Each shared pin has a select bit, and setting it hands the terminal to the pin's GPIO controls. While a shared pin is in alternate mode, its data, enable and invert bits can still be written and read back, but they have no effect on the terminal.

Software reaches the register through a write port with byte enables and a combinational read port. The block drives a value and an output enable for each pin, and the pad tri-states the terminal.

Top module: `gpio_pinmux_ctl`

## Requirements
- R1: After reset every register bit reads 0. Shared pins 0 and 1 are therefore in alternate mode, and pins 2 and 3 have output enable 0 and drive level 0.
- R2: A write updates only the byte lanes whose `wr_be` bit is 1. Lane n covers bits 8n+7:8n. A write with no byte enable set leaves every control bit unchanged.
- R3: The writable bits are exactly 0, 4, 5, 7, 8, 12, 13, 15, 16, 20, 21, 24, 28 and 29. Every other bit reads 0 and ignores writes.
- R4: Pin p (0 to 3) takes its data bit from bit 8p, its output enable from bit 8p+4 and its invert bit from bit 8p+5. In GPIO mode, `pin_oe[p]` equals the output-enable bit.
- R5: In GPIO mode, `pin_out[p]` equals the data bit XOR the invert bit.
- R6: In GPIO mode with output enable 0, reading bit 8p returns `pin_in[p]` XOR the invert bit. The pin value is taken through two flops, so a change on the pin becomes visible in the read data after the second rising clock edge.
- R7: In GPIO mode with output enable 1, reading bit 8p returns the stored data bit, whatever the pin level.
- R8: Shared pin p (0 or 1) is in alternate mode while its select bit 8p+7 is 0. In that mode, `pin_out[p]` follows `alt_out[p]` and `pin_oe[p]` follows `alt_oe[p]`, whatever its data, enable and invert bits hold.
- R9: In alternate mode, reading bit 8p returns the stored data bit, and changes on `pin_in[p]` are not visible.
- R10: Writing 1 to a select bit hands that terminal to its GPIO controls from the cycle after the write. Writing 0 returns it to the alternate function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane write enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read data |
| pin_in | input | NUM_PINS | Sampled terminal levels |
| pin_out | output | NUM_PINS | Level to drive on each terminal |
| pin_oe | output | NUM_PINS | Output enable for each terminal |
| alt_out | input | NUM_ALT | Alternate-function output level for shared pins |
| alt_oe | input | NUM_ALT | Alternate-function output enable for shared pins |

## Verification
The hardest situation to reach from the ports is a shared pin in alternate mode whose held data, enable and invert bits disagree with what the alternate function drives. That pin must then be released to GPIO mode and show those held controls from the very next cycle. The stimulus builds this in steps. It first writes conflicting control bits while the select bit is 0, then toggles the alternate inputs and the pin input to show that none of them leaks through. Finally it sets the select bit and scores the outputs on the cycle right after that write. The two-flop input latency is pinned down in the same way. Every pin change is scored once on the cycle after the change, where the old level is expected, and once a cycle later, where the new level is expected.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = REG_W / LANE_W;

   // field offsets inside one pin's byte lane
   localparam int unsigned FLD_DAT = 0;
   localparam int unsigned FLD_OE  = 4;
   localparam int unsigned FLD_INV = 5;
   localparam int unsigned FLD_SEL = 7;

   typedef struct packed {
      logic sel;
      logic inv;
      logic oe;
      logic dat;
   } pin_ctl_t;

   // bits that hold state for a given pin count and shared-pin count
   function automatic logic [REG_W-1:0] wr_mask(int unsigned pins, int unsigned alts);
      logic [REG_W-1:0] m;
      m = '0;
      for (int unsigned p = 0; p < LANES; p++) begin
         if (p < pins) begin
            m[p*LANE_W + FLD_DAT] = 1'b1;
            m[p*LANE_W + FLD_OE]  = 1'b1;
            m[p*LANE_W + FLD_INV] = 1'b1;
            if (p < alts) m[p*LANE_W + FLD_SEL] = 1'b1;
         end
      end
      return m;
   endfunction

   // writable bits whose read value is always the stored value
   function automatic logic [REG_W-1:0] ctl_mask(int unsigned pins, int unsigned alts);
      logic [REG_W-1:0] m;
      m = wr_mask(pins, alts);
      for (int unsigned p = 0; p < LANES; p++) m[p*LANE_W + FLD_DAT] = 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg
   import gpio_pinmux_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned NUM_ALT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_be,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctl_q
);

   localparam logic [REG_W-1:0] KEEP = wr_mask(NUM_PINS, NUM_ALT);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (wr_en && wr_be[l])
               lane_q <= wr_data[l*LANE_W +: LANE_W] & KEEP[l*LANE_W +: LANE_W];
         end
         assign ctl_q[l*LANE_W +: LANE_W] = lane_q;
      end
   endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
   import gpio_pinmux_pkg::*;
#(
   parameter bit SHARED = 1'b0
) (
   input  pin_ctl_t ctl,
   input  logic     pad_sync,
   input  logic     alt_out,
   input  logic     alt_oe,
   output logic     pad_out,
   output logic     pad_oe,
   output logic     rd_bit
);

   logic gpio_mode;

   generate
      if (SHARED) begin : g_shared
         assign gpio_mode = ctl.sel;
      end else begin : g_plain
         logic unused_sel;
         assign unused_sel = ctl.sel;
         assign gpio_mode  = 1'b1;
      end
   endgenerate

   always_comb begin
      if (gpio_mode) begin
         pad_out = ctl.dat ^ ctl.inv;
         pad_oe  = ctl.oe;
         rd_bit  = ctl.oe ? ctl.dat : (pad_sync ^ ctl.inv);
      end else begin
         pad_out = alt_out;
         pad_oe  = alt_oe;
         rd_bit  = ctl.dat;
      end
   end

endmodule

// File: rtl/gpio_pinmux_ctl.sv
module gpio_pinmux_ctl
   import gpio_pinmux_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned NUM_ALT     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [LANES-1:0]    wr_be,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_ALT-1:0]  alt_out,
   input  logic [NUM_ALT-1:0]  alt_oe
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > LANES) begin : g_bad_pins
         $error("NUM_PINS must be within 1..%0d", LANES);
      end
      if (NUM_ALT < 1 || NUM_ALT > NUM_PINS) begin : g_bad_alt
         $error("NUM_ALT must be within 1..NUM_PINS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [REG_W-1:0]    ctl_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] rd_bit;

   gpio_ctl_reg #(
      .NUM_PINS (NUM_PINS),
      .NUM_ALT  (NUM_ALT)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .ctl_q   (ctl_q)
   );

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         localparam int unsigned B = p * LANE_W;
         pin_ctl_t ctl_p;
         assign ctl_p = {ctl_q[B+FLD_SEL], ctl_q[B+FLD_INV], ctl_q[B+FLD_OE], ctl_q[B+FLD_DAT]};
         if (p < NUM_ALT) begin : g_mux
            gpio_pin_slice #(.SHARED(1'b1)) u_slice (
               .ctl      (ctl_p),
               .pad_sync (pin_sync[p]),
               .alt_out  (alt_out[p]),
               .alt_oe   (alt_oe[p]),
               .pad_out  (pin_out[p]),
               .pad_oe   (pin_oe[p]),
               .rd_bit   (rd_bit[p])
            );
         end else begin : g_gp
            gpio_pin_slice #(.SHARED(1'b0)) u_slice (
               .ctl      (ctl_p),
               .pad_sync (pin_sync[p]),
               .alt_out  (1'b0),
               .alt_oe   (1'b0),
               .pad_out  (pin_out[p]),
               .pad_oe   (pin_oe[p]),
               .rd_bit   (rd_bit[p])
            );
         end
      end
   endgenerate

   always_comb begin
      rd_data = ctl_q;
      for (int p = 0; p < NUM_PINS; p++) rd_data[p*LANE_W + FLD_DAT] = rd_bit[p];
   end

endmodule

// File: rtl/gpio_pinmux_ctl_chk.sv
module gpio_pinmux_ctl_chk
   import gpio_pinmux_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned NUM_ALT     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [LANES-1:0]    wr_be,
   input logic [REG_W-1:0]    wr_data,
   input logic [REG_W-1:0]    rd_data,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_ALT-1:0]  alt_out,
   input logic [NUM_ALT-1:0]  alt_oe
);

   localparam logic [REG_W-1:0] WM = wr_mask(NUM_PINS, NUM_ALT);
   localparam logic [REG_W-1:0] CM = ctl_mask(NUM_PINS, NUM_ALT);

   logic [1:0] up_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              up_cnt <= '0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data & CM) == '0);

   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~WM) == '0);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         a_r2_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_be[l]) |=>
               ((rd_data[l*LANE_W +: LANE_W] ^ $past(wr_data[l*LANE_W +: LANE_W]))
                & CM[l*LANE_W +: LANE_W]) == '0);
         a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_be[l]) |=>
               $stable(rd_data[l*LANE_W +: LANE_W] & CM[l*LANE_W +: LANE_W]));
      end

      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         localparam int unsigned B = p * LANE_W;
         logic gp;
         if (p < NUM_ALT) begin : g_sh
            assign gp = rd_data[B+FLD_SEL];
            a_r8_alt_drives: assert property (@(posedge clk) disable iff (!rst_n)
               !gp |-> (pin_out[p] == alt_out[p]) && (pin_oe[p] == alt_oe[p]));
            a_r9_alt_reads_stored: assert property (@(posedge clk) disable iff (!rst_n)
               (!gp && !wr_en) |=> $stable(rd_data[B+FLD_DAT]));
         end else begin : g_pl
            assign gp = 1'b1;
         end
         a_r4_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
            gp |-> pin_oe[p] == rd_data[B+FLD_OE]);
         a_r5_out_level: assert property (@(posedge clk) disable iff (!rst_n)
            (gp && rd_data[B+FLD_OE]) |-> pin_out[p] == (rd_data[B+FLD_DAT] ^ rd_data[B+FLD_INV]));
         if (SYNC_STAGES == 2) begin : g_lat
            a_r6_input_path: assert property (@(posedge clk) disable iff (!rst_n)
               (up_cnt == 2'd3 && gp && !rd_data[B+FLD_OE]) |->
                  rd_data[B+FLD_DAT] == ($past(pin_in[p], 2) ^ rd_data[B+FLD_INV]));
         end
      end
   endgenerate

endmodule

bind gpio_pinmux_ctl gpio_pinmux_ctl_chk #(
   .NUM_PINS    (NUM_PINS),
   .NUM_ALT     (NUM_ALT),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_be   (wr_be),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pin_in  (pin_in),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .alt_out (alt_out),
   .alt_oe  (alt_oe)
);

// File: tb/gpio_pinmux_ctl_tb_top.sv
module gpio_pinmux_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] WMASK = 32'h3131_B1B1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_be;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [3:0]  pin_in;
   logic [3:0]  pin_out;
   logic [3:0]  pin_oe;
   logic [1:0]  alt_out;
   logic [1:0]  alt_oe;

   gpio_pinmux_ctl dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .alt_out (alt_out),
      .alt_oe  (alt_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          due;
      logic [31:0] rd;
      logic [3:0]  po;
      logic [3:0]  oe;
      string       tag;
   } item_t;

   item_t sb[$];
   int cyc = 0;
   int n_total = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] m_reg;
   logic [3:0]  m_pin;
   logic [3:0]  m_alt_out;
   logic [3:0]  m_alt_oe;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare scoreboard items when they fall due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         n_total += 3;
         if (rd_data !== it.rd) begin
            n_fail++;
            $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
         end
         if (pin_out !== it.po) begin
            n_fail++;
            $display("FAIL %s pin_out actual=%b expected=%b", it.tag, pin_out, it.po);
         end
         if (pin_oe !== it.oe) begin
            n_fail++;
            $display("FAIL %s pin_oe actual=%b expected=%b", it.tag, pin_oe, it.oe);
         end
      end
   end

   task automatic push(input string tag, input int lat);
      item_t it;
      it.due = cyc + lat;
      it.rd  = m_reg;
      it.tag = tag;
      for (int p = 0; p < 4; p++) begin
         logic dat, oe, inv, gpio;
         dat  = m_reg[8*p];
         oe   = m_reg[8*p+4];
         inv  = m_reg[8*p+5];
         gpio = (p >= 2) || m_reg[8*p+7];
         if (gpio) begin
            it.po[p] = dat ^ inv;
            it.oe[p] = oe;
            if (!oe) it.rd[8*p] = m_pin[p] ^ inv;
         end else begin
            it.po[p] = m_alt_out[p];
            it.oe[p] = m_alt_oe[p];
         end
      end
      sb.push_back(it);
   endtask

   task automatic tick();
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic settle();
      while (sb.size() > 0) @(negedge clk);
   endtask

   task automatic do_write(input logic [3:0] be, input logic [31:0] d, input string tag);
      settle();
      tick();
      wr_en   = 1'b1;
      wr_be   = be;
      wr_data = d;
      for (int l = 0; l < 4; l++)
         if (be[l]) m_reg[8*l +: 8] = d[8*l +: 8] & WMASK[8*l +: 8];
      push(tag, 1);
      tick();
      wr_en = 1'b0;
      wr_be = '0;
   endtask

   task automatic set_pin(input logic [3:0] v, input string tag);
      settle();
      tick();
      pin_in = v;
      push(tag, 1);
      m_pin = v;
      push(tag, 2);
   endtask

   task automatic set_alt(input logic [1:0] o, input logic [1:0] e, input string tag);
      settle();
      tick();
      alt_out = o;
      alt_oe  = e;
      m_alt_out[1:0] = o;
      m_alt_oe[1:0]  = e;
      push(tag, 1);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_be   = '0;
      wr_data = '0;
      pin_in  = '0;
      alt_out = 2'b01;
      alt_oe  = 2'b10;
      m_reg     = '0;
      m_pin     = '0;
      m_alt_out = 4'b0001;
      m_alt_oe  = 4'b0010;
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      rst_n = 1'b1;
      push("R1 reset state", 1);

      do_write(4'hF, 32'hFFFF_FFFF, "R3 reserved bits stay zero");
      do_write(4'b0100, 32'h0000_0000, "R2 only lane 2 written");
      do_write(4'b0010, 32'h0000_0000, "R2 only lane 1 written");
      do_write(4'b1100, 32'h0011_0000, "R4 R5 pin2 drives data");
      do_write(4'b0100, 32'h0031_0000, "R5 invert flips driven level");
      set_pin(4'b1100, "R6 pin3 two-flop latency");
      do_write(4'b1000, 32'h2000_0000, "R6 invert on input read");
      do_write(4'b0100, 32'h0010_0000, "R7 enabled pin reads stored data");
      set_pin(4'b1000, "R7 pin change not visible when driving");
      do_write(4'b0001, 32'h0000_0031, "R8 held controls have no effect");
      set_alt(2'b10, 2'b01, "R8 terminal follows alternate inputs");
      do_write(4'b0001, 32'h0000_0001, "R9 alternate mode reads stored one");
      do_write(4'b0001, 32'h0000_0000, "R9 alternate mode reads stored zero");
      set_pin(4'b1001, "R9 pin change ignored in alternate mode");
      do_write(4'b0001, 32'h0000_0080, "R10 pin0 handed to GPIO");
      do_write(4'b0001, 32'h0000_0031, "R8 R10 pin0 back to alternate");
      do_write(4'b0001, 32'h0000_00B1, "R10 held controls take effect");
      do_write(4'b0010, 32'h0000_B000, "R10 pin1 handed to GPIO");
      do_write(4'b0010, 32'h0000_A000, "R6 pin1 input inverted");
      set_pin(4'b1011, "R6 pin1 input change");
      do_write(4'b0000, 32'hFFFF_FFFF, "R2 no lanes enabled");
      set_alt(2'b01, 2'b11, "R4 GPIO pins ignore alternate inputs");
      do_write(4'b0010, 32'h0000_3100, "R8 pin1 returned to alternate");
      settle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule